// File: doc/BRIEF.md
# Debounced level-sensitive external interrupt controller

This block watches a bank of external input lines and merges them into one interrupt request. Each line passes through a software gate and a per-line debounce filter. The filter counts a one-cycle millisecond strobe produced by an internal clock divider. The filtered level of a line is compared with a per-line polarity bit. When the line is armed and the level matches, a raw status bit latches. The raw status is ANDed with a per-line enable, and the OR of the result drives the interrupt output.

Triggering is by level only. To get edge behaviour, software flips the polarity after each event and arms the line again. Arming is a write-one pulse that readies the line to latch exactly one event. Software reaches the block through a plain synchronous register bus: address, write enable, write data and combinational read data.

Top module: `lvlirq_hub`

## Requirements
- R1: After reset every register is 0, `irq_o` is low, and every defined offset reads 0.
- R2: Offset 0x00 reads the filtered level of each line, with line n at bit n. The gate register at offset 0x04 admits line n only while its bit n is 1. A gated-off line filters towards 0.
- R3: A line whose period field is 0 is not filtered. Its level at 0x00 follows the gated input one clock later.
- R4: A line with period P > 0 takes a new level only after the gated input has differed from the held level for P consecutive strobes. The strobe fires once every CYC_PER_MS clocks. A disagreement shorter than that leaves the held level unchanged.
- R5: The polarity register is at 0x14, where bit 1 means active-high and 0 means active-low. The raw status at 0x1C sets bit n when line n is armed, gated on, and its filtered level equals its polarity bit.
- R6: Writing 1 to bit n at 0x28 arms line n, and writing 0 there does nothing. A line disarms when its status latches, so a persisting condition latches again only after a new arm. Offset 0x28 reads 0.
- R7: Writing 1 to bit n at 0x24 clears raw status bit n, and a 0 bit does nothing. A set in the same cycle wins over the clear. Offset 0x24 reads 0.
- R8: The enable register is at 0x18. Offset 0x20 reads raw status AND enable, and `irq_o` is high exactly while that value is nonzero.
- R9: The period register of line n is at 0x40 + 4n. It holds bits 11:0, and the bits above read 0. Writes to offsets outside the defined set change nothing, and those offsets read 0. Writes to 0x00, 0x1C and 0x20 are ignored.
- R10: If software flips the polarity after each latched event and re-arms the line, both a rising and a falling input transition produce an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NCH | External lines |
| addr_i | input | AW | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default 16 lines and 12-bit periods, but sets CYC_PER_MS to 4. At that divider a millisecond strobe arrives every four clocks, so debounce windows of a few strobes take only tens of cycles. This puts the acceptance bound and the glitch-rejection case within reach. Every line is swept through arm, latch, clear and re-arm with both polarities. The whole 8-bit address space is swept for undefined offsets, and every period register is written and read back.

// File: rtl/lvlirq_pkg.sv
package lvlirq_pkg;
  localparam int unsigned OFF_LEVEL = 32'h00;
  localparam int unsigned OFF_GATE  = 32'h04;
  localparam int unsigned OFF_POL   = 32'h14;
  localparam int unsigned OFF_ENA   = 32'h18;
  localparam int unsigned OFF_RAW   = 32'h1C;
  localparam int unsigned OFF_PEND  = 32'h20;
  localparam int unsigned OFF_CLR   = 32'h24;
  localparam int unsigned OFF_ARM   = 32'h28;
  localparam int unsigned OFF_PER   = 32'h40;

  // byte address of a line's period register
  function automatic int unsigned per_addr(input int unsigned ch);
    return OFF_PER + 4 * ch;
  endfunction

  // true when one more strobe completes the programmed window
  function automatic logic per_reached(input int unsigned cnt, input int unsigned per);
    return (cnt + 1) >= per;
  endfunction
endpackage

// File: rtl/lvlirq_tick.sv
module lvlirq_tick #(
  parameter int unsigned CYC_PER_MS = 32000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned TW = $clog2(CYC_PER_MS + 1);
  localparam logic [TW-1:0] LAST = TW'(CYC_PER_MS - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == LAST);

  // strobe is one cycle wide when the divider exceeds 1
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (CYC_PER_MS > 1 && tick_o) |=> !tick_o);
endmodule

// File: rtl/lvlirq_filter.sv
module lvlirq_filter
  import lvlirq_pkg::*;
#(
  parameter int unsigned PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gin_i,
  input  logic [PER_W-1:0] per_i,
  output logic             lvl_o
);
  logic [PER_W-1:0] cnt_q;
  logic             lvl_q;
  logic             bypass;
  logic             differ;

  assign bypass = (per_i == '0);
  assign differ = (gin_i != lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (bypass) begin
      lvl_q <= gin_i;
      cnt_q <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (per_reached(32'(cnt_q), 32'(per_i))) begin
        lvl_q <= gin_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;

  // a filtered line can only move on a strobe
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !bypass) |=> $stable(lvl_o));

  // an unfiltered line tracks its input one clock later
  assert_bypass_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (lvl_o == $past(gin_i)));
endmodule

// File: rtl/lvlirq_hub.sv
module lvlirq_hub
  import lvlirq_pkg::*;
#(
  parameter int unsigned NCH        = 16,
  parameter int unsigned PER_W      = 12,
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 16,
  parameter int unsigned CYC_PER_MS = 32000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NCH-1:0] gate_q, pol_q, ena_q, raw_q, armed_q;
  logic [NCH-1:0] lvl, gin, set_vec, clr_vec, arm_vec, pend;
  logic [PER_W-1:0] per_q [NCH];
  logic tick;
  logic [31:0] a32;

  assign a32 = 32'(addr_i);

  lvlirq_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  assign gin     = pin_i & gate_q;
  assign clr_vec = (wr_en_i && a32 == OFF_CLR) ? wdata_i[NCH-1:0] : '0;
  assign arm_vec = (wr_en_i && a32 == OFF_ARM) ? wdata_i[NCH-1:0] : '0;
  assign set_vec = armed_q & gate_q & ~(lvl ^ pol_q);
  assign pend    = raw_q & ena_q;
  assign irq_o   = |pend;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    lvlirq_filter #(.PER_W(PER_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .gin_i(gin[i]), .per_i(per_q[i]), .lvl_o(lvl[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        per_q[i] <= '0;
      end else if (wr_en_i && a32 == per_addr(i)) begin
        per_q[i] <= wdata_i[PER_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q  <= '0;
      pol_q   <= '0;
      ena_q   <= '0;
      raw_q   <= '0;
      armed_q <= '0;
    end else begin
      if (wr_en_i && a32 == OFF_GATE) gate_q <= wdata_i[NCH-1:0];
      if (wr_en_i && a32 == OFF_POL)  pol_q  <= wdata_i[NCH-1:0];
      if (wr_en_i && a32 == OFF_ENA)  ena_q  <= wdata_i[NCH-1:0];
      raw_q   <= set_vec | (raw_q & ~clr_vec);
      armed_q <= arm_vec | (armed_q & ~set_vec);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (a32 == OFF_LEVEL) rdata_o = DW'(lvl);
    if (a32 == OFF_GATE)  rdata_o = DW'(gate_q);
    if (a32 == OFF_POL)   rdata_o = DW'(pol_q);
    if (a32 == OFF_ENA)   rdata_o = DW'(ena_q);
    if (a32 == OFF_RAW)   rdata_o = DW'(raw_q);
    if (a32 == OFF_PEND)  rdata_o = DW'(pend);
    for (int i = 0; i < NCH; i++) begin
      if (a32 == per_addr(i)) rdata_o = DW'(per_q[i]);
    end
  end

  // set beats a clear aimed at the same line
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((raw_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  // a clear with no concurrent set empties the bit
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));

  // latching an event consumes the arm
  assert_disarm_on_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & ~arm_vec) != '0) |=> ((armed_q & $past(set_vec & ~arm_vec)) == '0));

  // a status bit rises only for an armed line
  assert_rise_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q)) != '0) |-> ((($past(armed_q)) & (raw_q & ~$past(raw_q))) == (raw_q & ~$past(raw_q))));
endmodule

// File: tb/lvlirq_hub_bench.sv
module lvlirq_hub_bench;
  localparam int NCH = 16;
  localparam int CYC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [15:0] v;

  lvlirq_hub #(.NCH(16), .PER_W(12), .AW(8), .DW(16), .CYC_PER_MS(CYC)) u_lvlirq_hub (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit is_defined(input int a);
    return a == 'h00 || a == 'h04 || a == 'h14 || a == 'h18 || a == 'h1C ||
           a == 'h20 || a == 'h24 || a == 'h28 || (a >= 'h40 && a < 'h80 && a % 4 == 0);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0);
    for (int a = 0; a < 256; a += 4) begin
      if (is_defined(a)) begin
        rd(8'(a), v);
        chk("R1 reset read", v, 16'h0);
      end
    end

    // R2/R3 level path, unfiltered
    wr(8'h04, 16'hFFFF);
    @(negedge clk);
    pin = 16'hA5C3;
    @(negedge clk);
    rd(8'h00, v);
    chk("R3 level one clock later", v, 16'hA5C3);
    wr(8'h04, 16'h00FF);
    cycles(1);
    rd(8'h00, v);
    chk("R2 gate masks level", v, 16'hA5C3 & 16'h00FF);
    wr(8'h00, 16'hFFFF);
    rd(8'h00, v);
    chk("R9 level write ignored", v, 16'h00C3);

    // R9 period registers
    for (int ch = 0; ch < NCH; ch++) begin
      wr(8'('h40 + 4 * ch), 16'hF000 | 16'((ch * 37 + 1) & 'hFFF));
    end
    for (int ch = 0; ch < NCH; ch++) begin
      rd(8'('h40 + 4 * ch), v);
      chk("R9 period readback", v, 16'((ch * 37 + 1) & 'hFFF));
      wr(8'('h40 + 4 * ch), 16'h0);
    end

    // R9 undefined offsets
    wr(8'h14, 16'h1234);
    wr(8'h18, 16'h0);
    for (int a = 0; a < 256; a++) begin
      if (!is_defined(a)) wr(8'(a), 16'hFFFF);
    end
    for (int a = 0; a < 256; a++) begin
      if (!is_defined(a)) begin
        rd(8'(a), v);
        chk("R9 undefined reads 0", v, 16'h0);
      end
    end
    rd(8'h04, v); chk("R9 gate untouched", v, 16'h00FF);
    rd(8'h14, v); chk("R9 polarity untouched", v, 16'h1234);
    rd(8'h1C, v); chk("R9 raw untouched", v, 16'h0);
    rd(8'h24, v); chk("R7 clear reads 0", v, 16'h0);

    // R5/R6/R7/R8/R10 per-line sweep
    pin = '0;
    wr(8'h04, 16'hFFFF);
    wr(8'h18, 16'hFFFF);
    wr(8'h14, 16'h0000);
    cycles(2);
    for (int ch = 0; ch < NCH; ch++) begin
      logic [15:0] b;
      b = 16'(1) << ch;
      wr(8'h14, b);
      wr(8'h28, b);
      rd(8'h28, v); chk("R6 arm reads 0", v, 16'h0);
      cycles(3);
      rd(8'h1C, v); chk("R5 no latch while level mismatches", v, 16'h0);
      pin = b;
      cycles(3);
      rd(8'h1C, v); chk("R5 rising latch", v, b);
      rd(8'h20, v); chk("R8 pending", v, b);
      chk("R8 irq high", {15'd0, irq}, 16'h1);
      wr(8'h24, 16'h0);
      rd(8'h1C, v); chk("R7 zero clear no effect", v, b);
      wr(8'h24, b);
      cycles(2);
      rd(8'h1C, v); chk("R6 no relatch without arm", v, 16'h0);
      chk("R8 irq low after clear", {15'd0, irq}, 16'h0);
      // R10 flip polarity for the falling transition
      wr(8'h14, 16'h0);
      wr(8'h28, b);
      cycles(3);
      rd(8'h1C, v); chk("R10 no event while high", v, 16'h0);
      pin = '0;
      cycles(3);
      rd(8'h1C, v); chk("R10 falling event", v, b);
      wr(8'h24, b);
    end

    // R8 enable masks pending but not raw
    wr(8'h14, 16'h0001);
    pin = 16'h0001;
    wr(8'h18, 16'h0);
    wr(8'h28, 16'h0001);
    cycles(3);
    rd(8'h1C, v); chk("R8 raw set while disabled", v, 16'h0001);
    rd(8'h20, v); chk("R8 pending masked", v, 16'h0);
    chk("R8 irq masked", {15'd0, irq}, 16'h0);
    wr(8'h24, 16'h0001);

    // R7 set wins over clear in the same cycle
    @(negedge clk);
    addr = 8'h28; wdata = 16'h0001; wr_en = 1'b1;
    @(negedge clk);
    addr = 8'h24;
    @(negedge clk);
    wr_en = 1'b0;
    rd(8'h1C, v); chk("R7 set beats clear", v, 16'h0001);
    wr(8'h24, 16'h0001);
    rd(8'h1C, v); chk("R7 clear", v, 16'h0);

    // R4 debounce on line 3, period 3 strobes
    pin = '0;
    wr(8'h4C, 16'd3);
    cycles(20);
    rd(8'h00, v); chk("R4 starts low", v & 16'h0008, 16'h0);
    pin = 16'h0008;
    cycles(2 * CYC);
    rd(8'h00, v); chk("R4 not accepted early", v & 16'h0008, 16'h0);
    cycles(CYC + 2);
    rd(8'h00, v); chk("R4 accepted after window", v & 16'h0008, 16'h0008);
    pin = '0;
    cycles(5);
    pin = 16'h0008;
    cycles(20);
    rd(8'h00, v); chk("R4 glitch rejected", v & 16'h0008, 16'h0008);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule